// File: doc/BRIEF.md
# EEPROM Erase/Write Cycle Sequencer

This block runs the non-volatile programming cycle that follows the STOP of a write transfer on a serial EEPROM. When a start request arrives, it captures the write buffer, the buffered byte count, the starting array address and the mode flag. It then steps through erase and write phases and strobes each result into a register array that stands in for the cells. The busy flag stays high until the whole cycle is over. Every phase lasts a fixed number of timebase ticks.

The timebase comes from one of two sources. One is an internal divider that produces a tick every `OSC_DIV` system clocks. The other is an external clock that the bus master toggles on a dedicated pin; it is synchronized and counted on its rising edges. The source is chosen by a latch pulse that the bus front end issues on the SCL falling edge after the eighth bit of the word address. A low programming-control pin at that pulse selects the external clock.

In byte mode each buffered byte gets its own erase phase and then its own write phase. In page mode one erase clears the whole aligned 8-byte block, and eight write phases follow. With the external clock, the total length is therefore an exact number of edges.

Top module: `eeprom_ew_seq`

## Requirements
- R1: A start pulse is accepted when busy is low, abort is low, and the count is valid. busy then rises at the next clock edge and stays high until the cycle ends.
- R2: A start pulse with abort high starts no cycle. busy stays low, no strobe or done pulse appears, and the array is unchanged.
- R3: A start pulse while busy has no effect. The running cycle keeps its length, addresses and data.
- R4: In byte mode with n bytes (1 to 8), buffer byte k (bits 8k+7..8k of `buf_data`) is handled as erase then write at address {base[9:8], base[7:0]+k}. The address wraps within its 256-byte block. Erase and write strobes never coincide.
- R5: In page mode, one erase strobe at {base[9:3], 3'b000} clears eight bytes. Eight write strobes follow, at {base[9:3], base[2:0]+k} for k = 0 to 7.
- R6: Each phase is 128 ticks, and one extra tick ends the cycle. busy therefore lasts n×256+1 ticks in byte mode and 1153 ticks in page mode.
- R7: A latch pulse with `ptc_n` low selects the external clock; with `ptc_n` high it selects the internal divider. A latch pulse while busy is ignored.
- R8: `done` is a one-cycle pulse in the first cycle in which busy is low after a cycle.
- R9: An erase strobe sets the byte(s) it covers to 8'hFF. A write strobe stores the buffered byte. `rd_data` shows the array contents at `rd_addr` combinationally.
- R10: In byte mode, a start pulse with a count of 0 or greater than 8 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_latch | input | 1 | Timebase selection latch pulse |
| ptc_n | input | 1 | Programming-control pin level; low selects external clock |
| ext_clk | input | 1 | Raw external timebase clock from the master |
| start | input | 1 | Start request pulse issued at STOP |
| abort | input | 1 | Transfer was aborted; suppress programming |
| page_mode | input | 1 | 1 = page mode, 0 = byte mode |
| byte_cnt | input | 4 | Number of buffered bytes |
| base_addr | input | 10 | Array address of the first buffered byte |
| buf_data | input | 64 | Buffered bytes; byte k in bits 8k+7..8k |
| rd_addr | input | 10 | Array read address |
| rd_data | output | 8 | Array contents at rd_addr |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-cycle pulse when busy falls |
| erase_stb | output | 1 | Erase phase completed this cycle |
| write_stb | output | 1 | Write phase completed this cycle |
| stb_addr | output | 10 | Address of the strobe in progress |

## Verification
busy rises at the first clock edge after an accepted start, so the bench samples it on the following falling edge. An external-clock edge reaches the tick logic two clocks after the pin rises and is counted at the third. The bench therefore holds each pin level for four clocks, which means every edge has been counted before the next sample. With the external clock, busy is checked high after one edge fewer than the cycle total and low after the last edge. In internal mode the tick arrives every `OSC_DIV` clocks from the accept edge, and busy is sampled two clocks before and two clocks after the computed fall. Strobes and done pulses are logged at each rising edge and compared afterwards against the expected address sequence and a count of one.

// File: rtl/eeprom_ew_seq.sv
module eeprom_ew_seq #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int BUF_DEPTH   = 8,
  parameter int BLOCK_W     = 8,
  parameter int PHASE_TICKS = 128,
  parameter int OSC_DIV     = 4,
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1),
  localparam int PG_W   = $clog2(BUF_DEPTH),
  localparam int PH_W   = $clog2(2 * BUF_DEPTH + 1),
  localparam int TCNT_W = $clog2(PHASE_TICKS),
  localparam int DIV_W  = $clog2(OSC_DIV + 1),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tb_latch,
  input  logic                        ptc_n,
  input  logic                        ext_clk,
  input  logic                        start,
  input  logic                        abort,
  input  logic                        page_mode,
  input  logic [CNT_W-1:0]            byte_cnt,
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic [BUF_DEPTH*DATA_W-1:0] buf_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        busy,
  output logic                        done,
  output logic                        erase_stb,
  output logic                        write_stb,
  output logic [ADDR_W-1:0]           stb_addr
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t                        st;
  logic                       ext_mode;
  logic [2:0]                 xs;
  logic [DIV_W-1:0]           divcnt;
  logic [TCNT_W-1:0]          tcnt;
  logic [PH_W-1:0]            ph;
  logic                       page_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [ADDR_W-1:0]          base_q;
  logic [BUF_DEPTH*DATA_W-1:0] buf_q;
  logic [DATA_W-1:0]          mem [DEPTH];

  assign busy = (st != S_IDLE);

  wire cnt_ok   = page_mode || (byte_cnt != '0 && byte_cnt <= CNT_W'(BUF_DEPTH));
  wire accept   = start && !abort && !busy && cnt_ok;
  wire ext_tick = xs[1] & ~xs[2];
  wire int_tick = (divcnt == DIV_W'(OSC_DIV - 1));
  wire tick     = busy && (ext_mode ? ext_tick : int_tick);
  wire ph_end   = (st == S_RUN) && tick && (tcnt == TCNT_W'(PHASE_TICKS - 1));

  wire                is_erase = page_q ? (ph == '0) : ~ph[0];
  wire [PG_W-1:0]     idx      = page_q ? PG_W'(ph - 1'b1) : ph[PG_W:1];
  wire [PH_W-1:0]     ph_last  = page_q ? PH_W'(BUF_DEPTH) : PH_W'({cnt_q, 1'b0} - 1'b1);

  logic [ADDR_W-1:0] a_byte, a_page, page_base, a_cur;
  logic [DATA_W-1:0] wr_byte;

  assign a_byte    = {base_q[ADDR_W-1:BLOCK_W], base_q[BLOCK_W-1:0] + BLOCK_W'(idx)};
  assign a_page    = {base_q[ADDR_W-1:PG_W], base_q[PG_W-1:0] + idx};
  assign page_base = {base_q[ADDR_W-1:PG_W], {PG_W{1'b0}}};
  assign a_cur     = page_q ? (is_erase ? page_base : a_page) : a_byte;
  assign wr_byte   = buf_q[idx*DATA_W +: DATA_W];
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (ph_end) begin
      if (!is_erase)
        mem[a_cur] <= wr_byte;
      else if (page_q)
        for (int i = 0; i < BUF_DEPTH; i++)
          mem[page_base + ADDR_W'(i)] <= {DATA_W{1'b1}};
      else
        mem[a_cur] <= {DATA_W{1'b1}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ext_mode  <= 1'b0;
      xs        <= '0;
      divcnt    <= '0;
      tcnt      <= '0;
      ph        <= '0;
      page_q    <= 1'b0;
      cnt_q     <= '0;
      base_q    <= '0;
      buf_q     <= '0;
      done      <= 1'b0;
      erase_stb <= 1'b0;
      write_stb <= 1'b0;
      stb_addr  <= '0;
    end else begin
      xs        <= {xs[1:0], ext_clk};
      done      <= 1'b0;
      erase_stb <= 1'b0;
      write_stb <= 1'b0;
      if (tb_latch && !busy) ext_mode <= ~ptc_n;
      divcnt <= (!busy || int_tick) ? '0 : divcnt + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_RUN;
          ph     <= '0;
          tcnt   <= '0;
          page_q <= page_mode;
          cnt_q  <= byte_cnt;
          base_q <= base_addr;
          buf_q  <= buf_data;
        end
        S_RUN: if (tick) begin
          if (ph_end) begin
            tcnt      <= '0;
            erase_stb <= is_erase;
            write_stb <= ~is_erase;
            stb_addr  <= a_cur;
            if (ph == ph_last) st <= S_TAIL;
            else               ph <= ph + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_TAIL: if (tick) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !busy && page_mode) |=> busy); // R1
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && abort && !busy) |=> !busy); // R2
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_stb && write_stb)); // R4
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb && page_q) |-> (stb_addr[PG_W-1:0] == '0)); // R5
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_latch && busy) |=> $stable(ext_mode)); // R7
  AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb || write_stb) |-> busy); // R9

endmodule

// File: tb/eeprom_ew_seq_tb.sv
`timescale 1ns/1ps
module eeprom_ew_seq_tb;
  localparam int DIV = 2;
  localparam int PT  = 128;

  logic clk = 0, rst_n = 0;
  logic tb_latch = 0, ptc_n = 1, ext_clk = 0, start = 0, abort = 0, page_mode = 0;
  logic [3:0]  byte_cnt = 0;
  logic [9:0]  base_addr = 0, rd_addr = 0, stb_addr;
  logic [63:0] buf_data = 0;
  logic [7:0]  rd_data;
  logic busy, done, erase_stb, write_stb;

  always #5 clk = ~clk;

  eeprom_ew_seq #(.ADDR_W(10), .DATA_W(8), .BUF_DEPTH(8), .BLOCK_W(8),
                  .PHASE_TICKS(PT), .OSC_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tb_latch(tb_latch), .ptc_n(ptc_n), .ext_clk(ext_clk),
    .start(start), .abort(abort), .page_mode(page_mode), .byte_cnt(byte_cnt),
    .base_addr(base_addr), .buf_data(buf_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .erase_stb(erase_stb), .write_stb(write_stb), .stb_addr(stb_addr));

  // {page, count, base, external}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 4'd1, 10'h155, 1'b1},
    {1'b0, 4'd3, 10'h0FE, 1'b1},
    {1'b1, 4'd8, 10'h12D, 1'b1},
    {1'b0, 4'd7, 10'h3FB, 1'b1},
    {1'b0, 4'd8, 10'h210, 1'b1},
    {1'b0, 4'd2, 10'h080, 1'b0}
  };

  int nchk = 0, nfail = 0, log_n = 0, done_n = 0;
  logic       log_w [64];
  logic [9:0] log_a [64];

  always @(posedge clk) begin
    if (erase_stb || write_stb) begin
      if (log_n < 64) begin log_w[log_n] = write_stb; log_a[log_n] = stb_addr; end
      log_n++;
    end
    if (done) done_n++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int v, input int k);
    return 8'(8'h3C + v * 8'h51 + k * 8'h17);
  endfunction

  function automatic logic [9:0] exp_addr(input logic pg, input logic [9:0] b, input int k);
    if (pg) return {b[9:3], 3'(b[2:0] + 3'(k))};
    return {b[9:8], 8'(b[7:0] + 8'(k))};
  endfunction

  task automatic ext_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1; repeat (4) @(negedge clk);
      ext_clk = 0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic sel_tb(input logic ext);
    @(negedge clk); ptc_n = ~ext; tb_latch = 1;
    @(negedge clk); tb_latch = 0; ptc_n = 1;
  endtask

  task automatic kick(input logic pg, input logic [3:0] n, input logic [9:0] b,
                      input logic [63:0] d, input logic ab);
    page_mode = pg; byte_cnt = n; base_addr = b; buf_data = d; abort = ab; start = 1;
    @(negedge clk); start = 0; abort = 0;
  endtask

  task automatic run_vec(input int v);
    logic pg, ext; logic [3:0] n; logic [9:0] b; logic [63:0] d;
    int total, nb, lb, db, ne;
    {pg, n, b, ext} = VEC[v];
    nb = pg ? 8 : int'(n);
    d = '0;
    for (int k = 0; k < 8; k++) d[k*8 +: 8] = dbyte(v, k);
    total = pg ? 9 * PT + 1 : nb * 2 * PT + 1;
    sel_tb(ext);
    lb = log_n; db = done_n;
    kick(pg, n, b, d, 1'b0);
    chk("R1 busy after start", busy, 1);
    if (ext) begin
      if (v == 0) begin
        ext_ticks(PT);
        rd_addr = b; #1;
        chk("R9 erased byte mid-cycle", rd_data, 8'hFF);
        ext_ticks(total - PT - 1);
      end else ext_ticks(total - 1);
      chk("R6 busy before final tick", busy, 1);
      ext_ticks(1);
      chk("R6 busy after final tick", busy, 0);
    end else begin
      repeat (total * DIV - 3) @(negedge clk);
      chk("R7 internal busy before end", busy, 1);
      repeat (4) @(negedge clk);
      chk("R7 internal busy after end", busy, 0);
    end
    chk("R8 one done pulse", done_n - db, 1);
    ne = pg ? 9 : 2 * nb;
    chk(pg ? "R5 strobe count" : "R4 strobe count", log_n - lb, ne);
    if (log_n - lb == ne) begin
      for (int i = 0; i < ne; i++) begin
        logic ew; logic [9:0] ea;
        if (pg) begin
          ew = (i != 0);
          ea = (i == 0) ? {b[9:3], 3'b000} : exp_addr(1'b1, b, i - 1);
          chk("R5 strobe kind", log_w[lb + i], ew);
          chk("R5 strobe addr", log_a[lb + i], ea);
        end else begin
          ew = i[0];
          ea = exp_addr(1'b0, b, i / 2);
          chk("R4 strobe kind", log_w[lb + i], ew);
          chk("R4 strobe addr", log_a[lb + i], ea);
        end
      end
    end
    for (int k = 0; k < nb; k++) begin
      @(negedge clk); rd_addr = exp_addr(pg, b, k); #1;
      chk("R9 array readback", rd_data, dbyte(v, k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int db, lb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R9 reset strobes", {erase_stb, write_stb}, 0);

    for (int v = 0; v < 6; v++) run_vec(v);

    // R2: aborted transfer leaves array at 0x155 unchanged
    sel_tb(1'b1);
    db = done_n; lb = log_n;
    kick(1'b0, 4'd1, 10'h155, 64'h0, 1'b1);
    chk("R2 abort busy", busy, 0);
    ext_ticks(300);
    rd_addr = 10'h155; #1;
    chk("R2 abort array", rd_data, dbyte(0, 0));
    chk("R2 abort no done", done_n - db, 0);
    chk("R2 abort no strobe", log_n - lb, 0);

    // R10: invalid byte counts
    kick(1'b0, 4'd0, 10'h155, 64'h0, 1'b0);
    chk("R10 count 0 ignored", busy, 0);
    kick(1'b0, 4'd9, 10'h155, 64'h0, 1'b0);
    chk("R10 count 9 ignored", busy, 0);

    // R3 + R7: start and latch while busy are ignored
    kick(1'b0, 4'd1, 10'h3A0, 64'h11, 1'b0);
    ext_ticks(10);
    kick(1'b0, 4'd8, 10'h3A0, {8{8'h99}}, 1'b0);
    @(negedge clk); tb_latch = 1; ptc_n = 1;
    @(negedge clk); tb_latch = 0;
    repeat (600) @(negedge clk);
    chk("R7 latch ignored while busy", busy, 1);
    ext_ticks(2 * PT + 1 - 11);
    chk("R3 busy before final tick", busy, 1);
    ext_ticks(1);
    chk("R3 cycle length unchanged", busy, 0);
    rd_addr = 10'h3A0; #1;
    chk("R3 first data kept", rd_data, 8'h11);
    rd_addr = 10'h3A1; #1;
    chk("R3 second start wrote nothing", rd_data == 8'h99, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule